// File: doc/BRIEF.md
# Color Wheel Index Delay Aligner

A spinning color filter wheel carries a sensor that pulses once per revolution, at the moment red light starts to fall on the display device. This block takes that raw sensor line, brings it into the system clock domain and keeps only its rising edges as index events. Each index event starts a programmable countdown. When the countdown expires, the block emits a one-clock delayed index pulse. That pulse, not any free-running counter, sets the phase of the display data against the filter segments. Changing the delay moves the data phase against the wheel, which is how the wheel is aligned electronically at the factory.

After each delayed index, a fixed guard interval holds display data back. This keeps the first color field clear of the spoke between filter segments. When the guard ends, a one-clock pulse marks the start of the first displayed (red) field.

The block also measures the number of clocks between index events. It raises a wheel fault when no index event arrives within a limit of about two nominal revolutions. At 120 revolutions per second a revolution lasts about 8.33 ms, and the first field starts about 220 µs after the index. The default parameters express these times in clocks of a 50 MHz system clock.

Top module: `cwi_aligner`

## Requirements
- R1: A raw sensor input that stays high for any number of clocks yields exactly one index event and hence exactly one delayed pulse. Only the low-to-high transition counts.
- R2: With a delay setting D, `idx_dly` is high for exactly one clock, in the cycle that follows the (D+4)-th rising clock edge after `sensor_raw` rises. Edge 1 is the first rising clock edge that samples the sensor high. The four cycles are two synchronizer stages, edge capture and the output register.
- R3: A delay setting of zero gives the delayed pulse after the 4th rising clock edge.
- R4: A new index event that arrives while a delay is still pending restarts the countdown from the new event, and the pending pulse is never emitted.
- R5: `dly_cfg` is captured only at an index event. A change while a delay is pending does not alter that delay; it takes effect from the next index event.
- R6: `data_hold` goes high in the same cycle as `idx_dly` and stays high for exactly GUARD_CYC cycles.
- R7: `data_go` is a one-clock pulse in the cycle where `data_hold` falls, GUARD_CYC cycles after `idx_dly`.
- R8: After an index event, `period_cyc` equals the number of clock cycles since the previous index event.
- R9: `wheel_fault` goes high once FAULT_LIMIT clocks pass with no index event. It returns low after the 3rd rising clock edge following a new sensor rise.
- R10: During and straight after reset, `idx_dly`, `data_hold`, `data_go` and `wheel_fault` are low and `period_cyc` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sensor_raw | input | 1 | Asynchronous index line from the wheel sensor |
| dly_cfg | input | DLY_W | Alignment delay in clocks, captured at each index |
| idx_dly | output | 1 | Delayed index pulse (start of red at the display) |
| data_hold | output | 1 | High while display data is held off after the delayed index |
| data_go | output | 1 | Pulse marking the first displayed field |
| period_cyc | output | PER_W | Clocks between the last two index events, saturating |
| wheel_fault | output | 1 | No index seen within FAULT_LIMIT clocks |

## Verification
The embedded properties assume the sensor line stays at each level for at least two clocks, so that two index events never fall in adjacent cycles. They also assume GUARD_CYC is at least one and FAULT_LIMIT fits in PER_W bits. The directed tests hold the sensor high for three or more clocks and keep it low for several clocks between pulses, including the early second pulse that forces a restart. They use a small guard and fault limit so that whole revolutions fit in a short run.

// File: rtl/cwi_pkg.sv
package cwi_pkg;

  // Counter step that stops at a limit
  function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // Period value reported at an index event, from the gap counter
  function automatic int unsigned period_of(int unsigned gap, int unsigned lim);
    return (gap >= lim) ? lim : gap + 1;
  endfunction

  // Clocks from first sensor sample to the delayed pulse
  function automatic int unsigned pulse_latency(int unsigned dly);
    return dly + 4;
  endfunction

endpackage

// File: rtl/cwi_sync.sv
module cwi_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [2:0] stg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stg_q <= 3'b000;
    else        stg_q <= {stg_q[1:0], async_i};
  end

  // stg_q[1] is the second synchronizer flop, stg_q[2] its delayed copy
  assign rise_o = stg_q[1] & ~stg_q[2];
endmodule

// File: rtl/cwi_delay.sv
module cwi_delay #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic [DLY_W-1:0] cfg_i,
  output logic             fire_o,
  output logic             pulse_o
);
  logic [DLY_W-1:0] cnt_q;
  logic             pend_q;
  logic             pulse_q;

  // an arriving index has priority and drops the expiring pulse
  assign fire_o  = pend_q && (cnt_q == '0) && !rise_i;
  assign pulse_o = pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire_o;
      if (rise_i) begin
        cnt_q  <= cfg_i;
        pend_q <= 1'b1;
      end else if (pend_q) begin
        if (cnt_q == '0) pend_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assert_restart_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |=> !pulse_q);

  assert_cfg_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !rise_i && cnt_q != '0) |=> (pend_q && cnt_q == $past(cnt_q) - 1'b1));

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> !pend_q);
endmodule

// File: rtl/cwi_guard.sv
module cwi_guard #(
  parameter int GUARD_CYC = 11000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic hold_o,
  output logic go_o
);
  localparam int GW = (GUARD_CYC < 2) ? 1 : $clog2(GUARD_CYC);

  logic [GW-1:0] gcnt_q;
  logic          hold_q;
  logic          go_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcnt_q <= '0;
      hold_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (fire_i) begin
        hold_q <= 1'b1;
        gcnt_q <= GW'(GUARD_CYC - 1);
      end else if (hold_q) begin
        if (gcnt_q == '0) begin
          hold_q <= 1'b0;
          go_q   <= 1'b1;
        end else begin
          gcnt_q <= gcnt_q - 1'b1;
        end
      end
    end
  end

  assign hold_o = hold_q;
  assign go_o   = go_q;

  assert_hold_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> hold_q);

  assert_go_after_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> $past(hold_q));
endmodule

// File: rtl/cwi_watch.sv
module cwi_watch #(
  parameter int PER_W       = 20,
  parameter int FAULT_LIMIT = 833334
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  output logic [PER_W-1:0] period_o,
  output logic             fault_o
);
  import cwi_pkg::*;

  logic [PER_W-1:0] gap_q;
  logic [PER_W-1:0] per_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= '0;
      per_q <= '0;
    end else if (rise_i) begin
      gap_q <= '0;
      per_q <= PER_W'(period_of(32'(gap_q), FAULT_LIMIT));
    end else begin
      gap_q <= PER_W'(sat_inc(32'(gap_q), FAULT_LIMIT));
    end
  end

  assign period_o = per_q;
  assign fault_o  = (gap_q == PER_W'(FAULT_LIMIT));

  assert_fault_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |=> !fault_o);

  assert_period_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |=> (per_q != '0));
endmodule

// File: rtl/cwi_aligner.sv
module cwi_aligner #(
  parameter int DLY_W       = 16,
  parameter int GUARD_CYC   = 11000,
  parameter int PER_W       = 20,
  parameter int FAULT_LIMIT = 833334
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sensor_raw,
  input  logic [DLY_W-1:0] dly_cfg,
  output logic             idx_dly,
  output logic             data_hold,
  output logic             data_go,
  output logic [PER_W-1:0] period_cyc,
  output logic             wheel_fault
);
  // internal events, named for the assertions
  logic idx_rise;
  logic dly_fire;

  cwi_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (sensor_raw),
    .rise_o  (idx_rise)
  );

  cwi_delay #(.DLY_W(DLY_W)) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_i  (idx_rise),
    .cfg_i   (dly_cfg),
    .fire_o  (dly_fire),
    .pulse_o (idx_dly)
  );

  cwi_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (dly_fire),
    .hold_o (data_hold),
    .go_o   (data_go)
  );

  cwi_watch #(.PER_W(PER_W), .FAULT_LIMIT(FAULT_LIMIT)) u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_i   (idx_rise),
    .period_o (period_cyc),
    .fault_o  (wheel_fault)
  );

  assert_one_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_rise |=> !idx_dly);

  assert_hold_with_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_dly |-> data_hold);
endmodule

// File: tb/cwi_aligner_bench.sv
module cwi_aligner_bench;
  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int G     = 5;
  localparam int LIM   = 200;
  localparam int PW    = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sensor_raw = 1'b0;
  logic [DW-1:0] dly_cfg = '0;
  logic          idx_dly, data_hold, data_go, wheel_fault;
  logic [PW-1:0] period_cyc;

  int n_chk = 0;
  int n_fail = 0;
  int k = 0;
  int np = 0;
  int lastk = -1;

  always #(CLK_P/2) clk = ~clk;

  cwi_aligner #(.DLY_W(DW), .GUARD_CYC(G), .PER_W(PW), .FAULT_LIMIT(LIM)) u_cwi_aligner (
    .clk(clk), .rst_n(rst_n), .sensor_raw(sensor_raw), .dly_cfg(dly_cfg),
    .idx_dly(idx_dly), .data_hold(data_hold), .data_go(data_go),
    .period_cyc(period_cyc), .wheel_fault(wheel_fault)
  );

  task automatic chk(string req, bit ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  // advance one clock; sample and drive a quarter period after the edge
  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
    k++;
    if (idx_dly) begin
      np++;
      lastk = k;
    end
  endtask

  task automatic obs_clear();
    k = 0; np = 0; lastk = -1;
  endtask

  task automatic idle(int n);
    sensor_raw = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) tick();
    chk("R10 outputs in reset", {idx_dly, data_hold, data_go, wheel_fault} == 4'b0,
        int'({idx_dly, data_hold, data_go, wheel_fault}), 0);
    rst_n = 1'b1;
    tick();
    chk("R10 outputs after reset", {idx_dly, data_hold, data_go, wheel_fault} == 4'b0,
        int'({idx_dly, data_hold, data_go, wheel_fault}), 0);
    chk("R10 period after reset", period_cyc == '0, int'(period_cyc), 0);
  endtask

  // one index with sensor held high for hi_len clocks
  task automatic t_delay(int d, int hi_len, string req);
    int e;
    int n;
    e = d + 4;
    n = ((hi_len > e + G) ? hi_len : e + G) + 10;
    dly_cfg = DW'(d);
    obs_clear();
    sensor_raw = 1'b1;
    for (int i = 0; i < n; i++) begin
      tick();
      if (k == hi_len) sensor_raw = 1'b0;
      if (k == e)         chk("R6 hold rises with pulse", data_hold == 1'b1, int'(data_hold), 1);
      if (k == e + G - 1) chk("R6 hold still high", data_hold == 1'b1, int'(data_hold), 1);
      if (k == e + G) begin
        chk("R6 hold falls after guard", data_hold == 1'b0, int'(data_hold), 0);
        chk("R7 go pulse at guard end", data_go == 1'b1, int'(data_go), 1);
      end
      if (k == e + G + 1) chk("R7 go is one clock", data_go == 1'b0, int'(data_go), 0);
    end
    chk({req, " pulse cycle"}, lastk == e, lastk, e);
    chk("R1 single pulse per index", np == 1, np, 1);
    idle(5);
  endtask

  task automatic t_restart();
    dly_cfg = DW'(20);
    obs_clear();
    sensor_raw = 1'b1;
    for (int i = 0; i < 60; i++) begin
      tick();
      if (k == 3)  sensor_raw = 1'b0;
      if (k == 10) sensor_raw = 1'b1;
      if (k == 13) sensor_raw = 1'b0;
    end
    chk("R4 pending pulse dropped", np == 1, np, 1);
    chk("R4 pulse timed from new index", lastk == 34, lastk, 34);
    idle(5);
  endtask

  task automatic t_cfg_change();
    dly_cfg = DW'(15);
    obs_clear();
    sensor_raw = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (k == 3) sensor_raw = 1'b0;
      if (k == 5) dly_cfg = DW'(3);
    end
    chk("R5 old delay kept while pending", lastk == 19, lastk, 19);
    chk("R5 one pulse", np == 1, np, 1);
    idle(5);
    obs_clear();
    sensor_raw = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (k == 3) sensor_raw = 1'b0;
    end
    chk("R5 new delay at next index", lastk == 7, lastk, 7);
    idle(5);
  endtask

  task automatic t_period(int p);
    dly_cfg = DW'(2);
    for (int r = 0; r < 3; r++) begin
      sensor_raw = 1'b1;
      for (int i = 0; i < 3; i++) tick();
      sensor_raw = 1'b0;
      for (int i = 3; i < p; i++) tick();
    end
    chk("R8 measured period", int'(period_cyc) == p, int'(period_cyc), p);
    chk("R9 no fault while spinning", wheel_fault == 1'b0, int'(wheel_fault), 0);
  endtask

  task automatic t_fault();
    idle(LIM + 5);
    chk("R9 fault after silence", wheel_fault == 1'b1, int'(wheel_fault), 1);
    obs_clear();
    sensor_raw = 1'b1;
    tick();
    tick();
    chk("R9 fault held before index", wheel_fault == 1'b1, int'(wheel_fault), 1);
    tick();
    chk("R9 fault cleared by index", wheel_fault == 1'b0, int'(wheel_fault), 0);
    idle(30);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..all actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    idle(5);
    t_delay(10, 30, "R2");
    t_delay(0, 3, "R3");
    t_restart();
    t_cfg_change();
    t_period(40);
    t_period(57);
    t_fault();
    summary();
    $finish;
  end
endmodule